// File: doc/BRIEF.md
# Walking-Ones Wire Continuity Tester

This block sequences a harness continuity test. For each wire k in turn it shifts a drive word with only bit k set into an external serial drive chain, strobes a shared latch, and then shifts the full response word back in from a serial sense chain. It builds the expected response for that step from a compact list of wire numbers held in an internal RAM. It walks the sensed and expected words bit by bit and emits one fault record for each position where they differ. Only one sensed word and one expected word are held at any time.

A host fills the list RAM through a plain write port while the block is idle. Lists sit back to back from address 0, one per drive step, and each ends with a terminator value. Storing only the wire numbers that should read 1 keeps a mostly-isolated harness to about two entries per wire instead of a full bitmap per wire. A start pulse runs every drive step. A one-cycle done pulse then reports the number of faults delivered.

Fault records leave on a valid/ready stream. A record is offered while `flt_valid` is high and is taken on a clock edge where `flt_ready` is also high. While `flt_ready` is low, the comparison halts, and the record stays on the port unchanged until it is taken. Records are never dropped or reordered.

Top module: `wire_walk_tester`

## Requirements
- R1: After reset, `done`, `list_err`, `flt_valid`, `chain_shift` and `chain_latch` are 0 and `fault_total` is 0.
- R2: For drive step k, the block holds `chain_shift` high for exactly N_WIRES consecutive cycles. It shifts the drive word most significant wire first, so that only wire k is 1 after the shift. It then raises `chain_latch` for one cycle with `chain_shift` low.
- R3: The cycle after the latch cycle has `chain_shift` low, which lets the sense chain load. From the next cycle on, the block shifts `sense_bit` in for N_WIRES cycles. The first bit is taken as wire N_WIRES-1 and the last as wire 0.
- R4: List entries below N_WIRES mark a wire that should read 1. An entry of N_WIRES or more ends the list, and both the exact value N_WIRES and larger values are accepted as the terminator. An empty list (terminator only) means no wire should read 1. Step k uses the k-th list found from address 0.
- R5: For each step, every wire whose sensed bit differs from its expected bit gives exactly one record. Records come in increasing step order and, within a step, in increasing sensed wire order. `flt_short` is 0 for an open (expected 1, sensed 0) and 1 for a short (expected 0, sensed 1).
- R6: While `flt_valid` is high and `flt_ready` is low, on the next cycle `flt_valid` stays high and `flt_drive`, `flt_sense` and `flt_short` are unchanged.
- R7: After the last step, `done` is high for exactly one cycle, and `fault_total` equals the number of records accepted during the run.
- R8: If a list holds N_WIRES entries and the next entry is not a terminator, the run stops and `list_err` goes high. No `done` is raised, and `chain_shift` stays low. `list_err` clears on the next start.
- R9: A start pulse during a run has no effect. The run ends with the same records and total and only one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a run when idle |
| load_we | input | 1 | List RAM write enable |
| load_addr | input | AW | List RAM write address |
| load_idx | input | IW | List entry (wire number or terminator) |
| chain_shift | output | 1 | Shift enable shared by drive and sense chains |
| chain_latch | output | 1 | Latch strobe shared by both chains |
| drive_bit | output | 1 | Serial data into the drive chain |
| sense_bit | input | 1 | Serial data out of the sense chain |
| flt_valid | output | 1 | Fault record offered |
| flt_ready | input | 1 | Consumer accepts the fault record |
| flt_drive | output | IW | Driven wire of the record |
| flt_sense | output | IW | Sensed wire of the record |
| flt_short | output | 1 | Record type: 0 open, 1 short |
| done | output | 1 | One-cycle pulse at the end of a run |
| fault_total | output | CW | Records accepted in the last run |
| list_err | output | 1 | List overran without a terminator |

## Verification
The bench drives a harness model with an open wire, a cross short and two wires joined on purpose that are listed as expected. A design that mixes up the meaning of the type bit, or scans wires in the wrong order, gives a record sequence that does not match. One list is closed with a large terminator value and one list holds only the terminator. A design that accepts only the exact value N_WIRES would run on into the next list and report false faults. A consumer that drops ready for two cycles out of every three shows whether a stalled record changes or is lost, and whether the count still matches. A list with one entry too many shows whether the block halts cleanly. A start pulse in the middle of a run shows whether the sequencing restarts, which would give a second done pulse or a different total.

// File: rtl/wwt_pkg.sv
package wwt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LIST,
    ST_DRIVE,
    ST_LATCH,
    ST_WAIT,
    ST_SENSE,
    ST_CMP,
    ST_DONE
  } wwt_state_e;
endpackage

// File: rtl/wwt_list_ram.sv
// Holds the expected-wire lists, back to back; written by the host,
// read combinationally by the list walker.
module wwt_list_ram #(
  parameter int DEPTH = 2048,
  parameter int IW    = 9,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);
  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/wwt_exp_vector.sv
// Byte-organised expected word: wire i lives in byte i/8 under mask 1<<(i%8).
module wwt_exp_vector #(
  parameter int N_WIRES = 360,
  parameter int IW      = 9,
  localparam int NB     = (N_WIRES + 7) / 8,
  localparam int BSW    = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               set_en,
  input  logic [IW-1:0]      set_idx,
  output logic [N_WIRES-1:0] vec
);
  logic [7:0]     bytes_q [NB];
  logic [BSW-1:0] bsel;
  logic [7:0]     bmask;

  assign bsel  = BSW'(set_idx >> 3);
  assign bmask = 8'd1 << set_idx[2:0];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int b = 0; b < NB; b++) bytes_q[b] <= '0;
    end else if (set_en) begin
      bytes_q[bsel] <= bytes_q[bsel] | bmask;
    end
  end

  for (genvar i = 0; i < N_WIRES; i++) begin : g_flat
    assign vec[i] = bytes_q[i / 8][i % 8];
  end
endmodule

// File: rtl/wwt_fault_scan.sv
// Walks sensed vs expected one wire per cycle, emitting a record on each
// difference and holding while the consumer is not ready.
module wwt_fault_scan #(
  parameter int N_WIRES = 360,
  parameter int IW      = 9,
  parameter int CW      = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_count,
  input  logic               go,
  input  logic [N_WIRES-1:0] sensed,
  input  logic [N_WIRES-1:0] expected,
  input  logic               ready,
  output logic               valid,
  output logic [IW-1:0]      pos,
  output logic               is_short,
  output logic               finish,
  output logic [CW-1:0]      count
);
  localparam logic [IW-1:0] LAST = IW'(N_WIRES - 1);

  logic active;
  logic differ;
  logic advance;

  assign differ   = sensed[pos] ^ expected[pos];
  assign valid    = active && differ;
  assign is_short = sensed[pos];
  assign advance  = active && (!differ || ready);
  assign finish   = advance && (pos == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      pos    <= '0;
      count  <= '0;
    end else begin
      if (clr_count) count <= '0;
      else if (valid && ready) count <= count + 1'b1;
      if (go) begin
        active <= 1'b1;
        pos    <= '0;
      end else if (advance) begin
        if (pos == LAST) active <= 1'b0;
        else pos <= pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wire_walk_tester.sv
module wire_walk_tester
  import wwt_pkg::*;
#(
  parameter int N_WIRES    = 360,
  parameter int LIST_DEPTH = 2048,
  localparam int IW = $clog2(N_WIRES + 1),
  localparam int AW = $clog2(LIST_DEPTH),
  localparam int CW = $clog2(N_WIRES * N_WIRES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          load_we,
  input  logic [AW-1:0] load_addr,
  input  logic [IW-1:0] load_idx,
  output logic          chain_shift,
  output logic          chain_latch,
  output logic          drive_bit,
  input  logic          sense_bit,
  output logic          flt_valid,
  input  logic          flt_ready,
  output logic [IW-1:0] flt_drive,
  output logic [IW-1:0] flt_sense,
  output logic          flt_short,
  output logic          done,
  output logic [CW-1:0] fault_total,
  output logic          list_err
);
  localparam logic [IW-1:0] LAST = IW'(N_WIRES - 1);
  localparam logic [IW-1:0] NW   = IW'(N_WIRES);

  wwt_state_e         st;
  logic [IW-1:0]      vec_k, bitpos, cnt;
  logic [AW-1:0]      ptr;
  logic [IW-1:0]      entry;
  logic               entry_end;
  logic [N_WIRES-1:0] sense_vec, exp_vec;
  logic               set_en, clr_exp, scan_go, scan_fin, run_begin;

  assign entry_end = (entry >= NW);
  assign run_begin = (st == ST_IDLE) && start;
  assign set_en    = (st == ST_LIST) && !entry_end && (cnt != NW);
  assign scan_go   = (st == ST_SENSE) && (bitpos == '0);
  assign clr_exp   = run_begin || ((st == ST_CMP) && scan_fin);

  assign chain_shift = (st == ST_DRIVE) || (st == ST_SENSE);
  assign chain_latch = (st == ST_LATCH);
  assign drive_bit   = (st == ST_DRIVE) && (bitpos == vec_k);
  assign done        = (st == ST_DONE);
  assign flt_drive   = vec_k;

  wwt_list_ram #(.DEPTH(LIST_DEPTH), .IW(IW)) u_ram (
    .clk  (clk),
    .we   (load_we),
    .waddr(load_addr),
    .wdata(load_idx),
    .raddr(ptr),
    .rdata(entry)
  );

  wwt_exp_vector #(.N_WIRES(N_WIRES), .IW(IW)) u_exp (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_exp),
    .set_en (set_en),
    .set_idx(entry),
    .vec    (exp_vec)
  );

  wwt_fault_scan #(.N_WIRES(N_WIRES), .IW(IW), .CW(CW)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_count(run_begin),
    .go       (scan_go),
    .sensed   (sense_vec),
    .expected (exp_vec),
    .ready    (flt_ready),
    .valid    (flt_valid),
    .pos      (flt_sense),
    .is_short (flt_short),
    .finish   (scan_fin),
    .count    (fault_total)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      vec_k     <= '0;
      bitpos    <= '0;
      cnt       <= '0;
      ptr       <= '0;
      sense_vec <= '0;
      list_err  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          vec_k    <= '0;
          ptr      <= '0;
          cnt      <= '0;
          list_err <= 1'b0;
          st       <= ST_LIST;
        end
        ST_LIST: begin
          if (entry_end) begin
            ptr    <= ptr + 1'b1;
            bitpos <= LAST;
            st     <= ST_DRIVE;
          end else if (cnt == NW) begin
            list_err <= 1'b1;
            st       <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
            ptr <= ptr + 1'b1;
          end
        end
        ST_DRIVE: begin
          if (bitpos == '0) st <= ST_LATCH;
          else bitpos <= bitpos - 1'b1;
        end
        ST_LATCH: st <= ST_WAIT;
        ST_WAIT: begin
          bitpos <= LAST;
          st     <= ST_SENSE;
        end
        ST_SENSE: begin
          sense_vec <= {sense_vec[N_WIRES-2:0], sense_bit};
          if (bitpos == '0) st <= ST_CMP;
          else bitpos <= bitpos - 1'b1;
        end
        ST_CMP: if (scan_fin) begin
          if (vec_k == LAST) st <= ST_DONE;
          else begin
            vec_k <= vec_k + 1'b1;
            cnt   <= '0;
            st    <= ST_LIST;
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wwt_checker.sv
module wwt_checker #(
  parameter int IW = 9,
  parameter int CW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          list_err,
  input logic          chain_shift,
  input logic          chain_latch,
  input logic          drive_bit,
  input logic          flt_valid,
  input logic          flt_ready,
  input logic [IW-1:0] flt_drive,
  input logic [IW-1:0] flt_sense,
  input logic          flt_short,
  input logic [CW-1:0] fault_total
);
  a_r6_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && !flt_ready |=> flt_valid);
  a_r6_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && !flt_ready |=> $stable(flt_drive) && $stable(flt_sense) && $stable(flt_short));
  a_r2_latch_alone: assert property (@(posedge clk) disable iff (!rst_n)
    chain_latch |-> !chain_shift);
  a_r2_latch_single: assert property (@(posedge clk) disable iff (!rst_n)
    chain_latch |=> !chain_latch && !chain_shift);
  a_r2_drive_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
    drive_bit |-> chain_shift);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    list_err |-> !chain_shift && !flt_valid && !done);
  a_r5_no_record_while_shifting: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> !chain_shift && !chain_latch);
  a_r7_total_steady_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(fault_total));
endmodule

bind wire_walk_tester wwt_checker #(.IW(IW), .CW(CW)) u_wwt_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .done       (done),
  .list_err   (list_err),
  .chain_shift(chain_shift),
  .chain_latch(chain_latch),
  .drive_bit  (drive_bit),
  .flt_valid  (flt_valid),
  .flt_ready  (flt_ready),
  .flt_drive  (flt_drive),
  .flt_sense  (flt_sense),
  .flt_short  (flt_short),
  .fault_total(fault_total)
);

// File: tb/wire_walk_tester_tb.sv
`timescale 1ns/1ps
module wire_walk_tester_tb;
  localparam int N  = 12;
  localparam int D  = 64;
  localparam int IW = $clog2(N + 1);
  localparam int AW = $clog2(D);
  localparam int CW = $clog2(N * N + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic load_we = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [IW-1:0] load_idx = '0;
  logic chain_shift, chain_latch, drive_bit, sense_bit;
  logic flt_valid, flt_ready = 1'b1, flt_short, done, list_err;
  logic [IW-1:0] flt_drive, flt_sense;
  logic [CW-1:0] fault_total;

  always #2.5 clk = ~clk;

  wire_walk_tester #(.N_WIRES(N), .LIST_DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load_we(load_we), .load_addr(load_addr), .load_idx(load_idx),
    .chain_shift(chain_shift), .chain_latch(chain_latch),
    .drive_bit(drive_bit), .sense_bit(sense_bit),
    .flt_valid(flt_valid), .flt_ready(flt_ready),
    .flt_drive(flt_drive), .flt_sense(flt_sense), .flt_short(flt_short),
    .done(done), .fault_total(fault_total), .list_err(list_err)
  );

  int checks = 0, fails = 0;
  logic [N-1:0] exp_m [N];   // what the lists say
  logic [N-1:0] act   [N];   // how the harness is really wired

  // ---------------- harness / chain model ----------------
  logic [N-1:0] drive_sr = '0, cap = '0, sense_sr = '0;
  logic latch_d = 1'b0;
  int lat_k = 0, cap_err = 0;
  assign sense_bit = sense_sr[N-1];

  always @(posedge clk) begin
    logic [N-1:0] resp;
    if (chain_shift) drive_sr <= {drive_sr[N-2:0], drive_bit};
    latch_d <= chain_latch;
    if (chain_latch) begin
      cap <= drive_sr;
      if (drive_sr != (N'(1) << lat_k)) cap_err++;
      lat_k++;
    end
    if (latch_d) begin
      resp = '0;
      for (int i = 0; i < N; i++) if (cap[i]) resp = resp | act[i];
      sense_sr <= resp;
    end else if (chain_shift) begin
      sense_sr <= {sense_sr[N-2:0], 1'b0};
    end
  end

  // ---------------- monitor ----------------
  int cyc = 0, bp_mode = 0;
  int run_len = 0, since = 0, drv_err = 0, gap_err = 0, stall_err = 0;
  int done_cnt = 0, tot_at_done = 0, err_shift = 0, nrec = 0;
  bit since_on = 0, prev_stall = 0;
  logic [IW-1:0] pd, ps; logic pt;
  int rec_d [256]; int rec_s [256]; int rec_t [256];

  always @(negedge clk) begin
    cyc++;
    flt_ready = (bp_mode != 0) ? ((cyc % 3) == 0) : 1'b1;
    if (prev_stall && (!flt_valid || flt_drive != pd || flt_sense != ps || flt_short != pt))
      stall_err++;
    prev_stall = flt_valid && !flt_ready;
    pd = flt_drive; ps = flt_sense; pt = flt_short;
    if (flt_valid && flt_ready && nrec < 256) begin
      rec_d[nrec] = int'(flt_drive); rec_s[nrec] = int'(flt_sense);
      rec_t[nrec] = int'(flt_short); nrec++;
    end
    if (since_on) since++;
    if (chain_shift && since_on) begin
      if (since != 2) gap_err++;
      since_on = 0;
    end
    if (chain_latch) begin
      if (run_len != N) drv_err++;
      since = 0; since_on = 1;
    end
    if (!chain_shift) run_len = 0; else run_len++;
    if (done) begin done_cnt++; tot_at_done = int'(fault_total); end
    if (list_err && chain_shift) err_shift++;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected run end");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input int a, input int e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, a, e);
    end
  endtask

  task automatic wr(input int a, input int v);
    @(posedge clk); #1;
    load_we = 1'b1; load_addr = AW'(a); load_idx = IW'(v);
    @(posedge clk); #1;
    load_we = 1'b0;
  endtask

  // lists back to back; odd steps close with 15 (>= N), even with N exactly
  task automatic load_lists();
    int a = 0;
    for (int k = 0; k < N; k++) begin
      for (int c = 0; c < N; c++) if (exp_m[k][c]) begin wr(a, c); a++; end
      wr(a, (k % 2) ? 15 : N); a++;
    end
  endtask

  task automatic set_identity();
    for (int k = 0; k < N; k++) begin
      exp_m[k] = N'(1) << k;
      act[k]   = N'(1) << k;
    end
  endtask

  task automatic run(input bit second_start, input int limit);
    done_cnt = 0; nrec = 0; drv_err = 0; gap_err = 0; stall_err = 0;
    cap_err = 0; lat_k = 0; err_shift = 0; run_len = 0; since_on = 0;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (done_cnt > 0 || list_err) break;
      if (second_start && i == 100) begin
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
      end
    end
    repeat (6) @(negedge clk);
  endtask

  // run and compare against faults computed from exp_m / act
  task automatic run_and_check(input string tag, input bit second_start);
    int ed [256]; int es [256]; int et [256]; int ne = 0; bit seq_ok = 1;
    for (int k = 0; k < N; k++)
      for (int c = 0; c < N; c++)
        if (exp_m[k][c] != act[k][c]) begin
          ed[ne] = k; es[ne] = c; et[ne] = act[k][c] ? 1 : 0; ne++;
        end
    run(second_start, 5000);
    check(done_cnt == 1, {tag, " R7 done pulses"}, done_cnt, 1);
    check(tot_at_done == ne, {tag, " R7 fault_total"}, tot_at_done, ne);
    check(nrec == ne, {tag, " R5 record count"}, nrec, ne);
    for (int i = 0; i < ne && i < nrec; i++)
      if (rec_d[i] != ed[i] || rec_s[i] != es[i] || rec_t[i] != et[i]) begin
        seq_ok = 0;
        $display("FAIL %s R5 record %0d: actual %0d/%0d/%0d expected %0d/%0d/%0d",
                 tag, i, rec_d[i], rec_s[i], rec_t[i], ed[i], es[i], et[i]);
      end
    checks++; if (!seq_ok) fails++;
    check(drv_err == 0 && cap_err == 0, {tag, " R2 drive shift/latch"}, drv_err + cap_err, 0);
    check(gap_err == 0, {tag, " R3 sense start gap"}, gap_err, 0);
    check(stall_err == 0, {tag, " R6 stalled record held"}, stall_err, 0);
    check(list_err == 1'b0, {tag, " R8 no list error"}, int'(list_err), 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(done == 0 && flt_valid == 0 && list_err == 0, "R1 status idle",
          int'({done, flt_valid, list_err}), 0);
    check(chain_shift == 0 && chain_latch == 0, "R1 chains idle",
          int'({chain_shift, chain_latch}), 0);
    check(fault_total == 0, "R1 fault_total", int'(fault_total), 0);
  endtask

  task automatic t_clean();
    set_identity();
    load_lists();
    bp_mode = 0;
    run_and_check("clean R4", 0);
  endtask

  task automatic t_open_short();
    set_identity();
    act[3] = '0;                           // wire 3 open
    act[5] = act[5] | (N'(1) << 7);        // 5 shorted to 7
    act[7] = act[7] | (N'(1) << 5);
    exp_m[2] = exp_m[2] | (N'(1) << 9);    // intended link 2-9
    exp_m[9] = exp_m[9] | (N'(1) << 2);
    act[2] = exp_m[2]; act[9] = exp_m[9];
    exp_m[10] = '0; act[10] = '0;          // empty list, wire not fitted (R4)
    load_lists();
    bp_mode = 0;
    run_and_check("open_short R5", 0);
  endtask

  task automatic t_backpressure();
    bp_mode = 1;
    run_and_check("backpressure R6", 0);
    bp_mode = 0;
  endtask

  task automatic t_start_ignored();
    run_and_check("restart R9", 1);
  endtask

  task automatic t_list_err();
    for (int a = 0; a <= N; a++) wr(a, 1);  // N+1 entries, no terminator
    run(0, 300);
    check(list_err == 1'b1, "R8 list_err raised", int'(list_err), 1);
    check(done_cnt == 0, "R8 no done", done_cnt, 0);
    repeat (20) @(negedge clk);
    check(err_shift == 0 && chain_shift == 0, "R8 chains stopped", err_shift, 0);
    check(list_err == 1'b1, "R8 flag held", int'(list_err), 1);
  endtask

  task automatic t_recover();
    set_identity();
    load_lists();
    run_and_check("recover R8", 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_clean();
    t_open_short();
    t_backpressure();
    t_start_ignored();
    t_list_err();
    t_recover();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule